// File: doc/BRIEF.md
# Suspend State Scan Port

This block gives software a way to save and restore the full internal state of a legacy audio engine across a power cycle. It holds a 268-bit image of the engine's flip-flops. Software reaches that image through one byte-wide data register. Each access to that register moves an internal byte pointer forward, so the whole image passes through the port one byte at a time, least significant byte first.

Raising the scan-enable input takes a parallel snapshot of the engine state and rewinds the pointer. Software then reads 34 bytes to save the state. To restore, it writes 34 bytes instead, and after the final write the block presents the rebuilt image to the engine with a one-cycle load strobe. A second read-only register returns the engine's current synthesizer register index.

Requests arrive on a valid/ready channel. `req_ready` is low for exactly one cycle: the cycle in which scan-enable rises and the snapshot is taken. In every other cycle a valid request is accepted at once. A request that is refused must be held unchanged until it is accepted. Read data comes back as a registered response one cycle after acceptance. The response channel has no back-pressure, so the requester must always be able to take it.

Top module: `sus_scan_port`

## Requirements
- R1: After reset, `rsp_valid` and `load_valid` are 0, `rsp_data` is 00h, `load_state` is all zero, and `req_ready` is 1 while scan-enable stays low.
- R2: In the cycle where `scan_en` is 1 and was 0 in the previous cycle, `req_ready` is 0, no request is accepted, `cap_state` is copied into the image and the byte pointer returns to 0.
- R3: With `scan_en` high, a read of the data register (address F1h) returns image byte k, which is image bits 8k+7 down to 8k, with k the byte pointer. Byte 0 comes out first.
- R4: The last byte (k = 33) carries image bits 267..264 in bits 3..0, and bits 7..4 read as 0.
- R5: Every accepted data-register access made with `scan_en` high and pointer below 34 adds one to the pointer. This holds for reads and writes alike, and both share the same pointer.
- R6: With `scan_en` high, a write of the data register stores `req_wdata` into image byte k. For k = 33, only bits 3..0 are kept. `load_state` always shows the current image.
- R7: `load_valid` pulses high for exactly one cycle. It follows the cycle in which a write to byte 33 was accepted, and it is never high at any other time.
- R8: With `scan_en` high and pointer at 34, data-register reads return 00h and writes leave the image unchanged.
- R9: With `scan_en` low, data-register reads return 00h, writes leave the image unchanged, and the pointer does not move.
- R10: A read of the index register (address F2h) returns `synth_index` as it stood when the read was accepted. Writes to that register have no effect, and neither kind of access moves the pointer.
- R11: Reads of any other address return 00h, and writes to any other address have no effect.
- R12: `rsp_valid` is high in the cycle right after each accepted read, and only then. Writes never produce a response. `rsp_data` keeps its value between responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Scan session enable; a rising level triggers the snapshot |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | 8 | Read response data |
| synth_index | input | 8 | Engine's current synthesizer register index |
| cap_state | input | 268 | Live engine flip-flop state, sampled at the snapshot |
| load_valid | output | 1 | One-cycle strobe: apply `load_state` to the engine |
| load_state | output | 268 | Current state image |

## Verification
The hardest case to reach is a request that is already waiting when scan-enable rises. It has to be refused in the snapshot cycle and then accepted in the next cycle against a freshly rewound pointer. The bench creates this by raising `scan_en` and `req_valid` on the same edge. The partial final byte is the other hard case, and it is hit by writing FFh to byte 33 and then reading the image back. After that, accesses continue past the end of the image, and scan-enable is dropped and raised again partway through a session. This shows that the pointer and the image recover exactly as required.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;
  typedef enum logic [1:0] {
    ACC_DATA  = 2'd0,
    ACC_INDEX = 2'd1,
    ACC_OTHER = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_port_pkg::*;
#(
  parameter int NBYTES = 34,
  parameter int PTR_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  input  logic             req_valid,
  input  logic             req_write,
  input  acc_kind_e        kind,
  output logic             req_ready,
  output logic             capture,
  output logic             in_win,
  output logic             data_wr,
  output logic [PTR_W-1:0] ptr,
  output logic             load_valid
);
  logic             scan_q;
  logic [PTR_W-1:0] ptr_q;
  logic             acc;
  logic             data_acc;

  // the snapshot cycle is the only one that refuses a request
  assign capture   = scan_en & ~scan_q;
  assign req_ready = ~capture;
  assign acc       = req_valid & req_ready;
  assign in_win    = scan_en & (ptr_q < PTR_W'(NBYTES));
  assign data_acc  = acc & in_win & (kind == ACC_DATA);
  assign data_wr   = data_acc & req_write;
  assign ptr       = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q     <= 1'b0;
      ptr_q      <= '0;
      load_valid <= 1'b0;
    end else begin
      scan_q     <= scan_en;
      load_valid <= data_wr & (ptr_q == PTR_W'(NBYTES - 1));
      if (capture)       ptr_q <= '0;
      else if (data_acc) ptr_q <= ptr_q + PTR_W'(1);
    end
  end
endmodule

// File: rtl/scan_chain_store.sv
module scan_chain_store #(
  parameter int STATE_BITS = 268,
  parameter int BYTE_W     = 8,
  parameter int NBYTES     = 34,
  parameter int PTR_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  capture,
  input  logic [STATE_BITS-1:0] cap_state,
  input  logic                  wr_en,
  input  logic [BYTE_W-1:0]     wdata,
  input  logic [PTR_W-1:0]      ptr,
  output logic [BYTE_W-1:0]     rd_byte,
  output logic [STATE_BITS-1:0] state_img
);
  logic [BYTE_W-1:0] lanes [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    localparam int LO = g * BYTE_W;
    localparam int VB = (STATE_BITS - LO < BYTE_W) ? (STATE_BITS - LO) : BYTE_W;
    localparam logic [BYTE_W-1:0] MASK = BYTE_W'((65'd1 << VB) - 65'd1);
    logic [BYTE_W-1:0] lane_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          lane_q <= '0;
      else if (capture)                    lane_q <= BYTE_W'(cap_state[LO +: VB]);
      else if (wr_en && ptr == PTR_W'(g))  lane_q <= wdata & MASK;
    end

    assign lanes[g]              = lane_q;
    assign state_img[LO +: VB]   = lane_q[VB-1:0];
  end

  // byte selected by the pointer; past the end it reads zero
  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NBYTES; i++)
      if (ptr == PTR_W'(i)) rd_byte = lanes[i];
  end
endmodule

// File: rtl/scan_rsp_reg.sv
module scan_rsp_reg
  import scan_port_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_acc,
  input  acc_kind_e         kind,
  input  logic              in_win,
  input  logic [BYTE_W-1:0] rd_byte,
  input  logic [BYTE_W-1:0] synth_index,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data
);
  logic [BYTE_W-1:0] rsp_next;

  always_comb begin
    unique case (kind)
      ACC_DATA:  rsp_next = in_win ? rd_byte : '0;
      ACC_INDEX: rsp_next = synth_index;
      default:   rsp_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_acc;
      if (rd_acc) rsp_data <= rsp_next;
    end
  end
endmodule

// File: rtl/sus_scan_port.sv
module sus_scan_port
  import scan_port_pkg::*;
#(
  parameter int                STATE_BITS = 268,
  parameter int                BYTE_W     = 8,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] DATA_OFS   = 8'hF1,
  parameter logic [ADDR_W-1:0] INDEX_OFS  = 8'hF2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scan_en,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [BYTE_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  output logic [BYTE_W-1:0]     rsp_data,
  input  logic [BYTE_W-1:0]     synth_index,
  input  logic [STATE_BITS-1:0] cap_state,
  output logic                  load_valid,
  output logic [STATE_BITS-1:0] load_state
);
  localparam int NBYTES = (STATE_BITS + BYTE_W - 1) / BYTE_W;
  localparam int PTR_W  = $clog2(NBYTES + 1);

  acc_kind_e         kind;
  logic              capture;
  logic              in_win;
  logic              data_wr;
  logic [PTR_W-1:0]  ptr;
  logic [BYTE_W-1:0] rd_byte;
  logic              rd_acc;

  always_comb begin
    if (req_addr == DATA_OFS)       kind = ACC_DATA;
    else if (req_addr == INDEX_OFS) kind = ACC_INDEX;
    else                            kind = ACC_OTHER;
  end

  assign rd_acc = req_valid & req_ready & ~req_write;

  scan_ctrl #(.NBYTES(NBYTES), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .req_valid(req_valid),
    .req_write(req_write), .kind(kind), .req_ready(req_ready),
    .capture(capture), .in_win(in_win), .data_wr(data_wr), .ptr(ptr),
    .load_valid(load_valid)
  );

  scan_chain_store #(.STATE_BITS(STATE_BITS), .BYTE_W(BYTE_W), .NBYTES(NBYTES),
                     .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .capture(capture), .cap_state(cap_state),
    .wr_en(data_wr), .wdata(req_wdata), .ptr(ptr), .rd_byte(rd_byte),
    .state_img(load_state)
  );

  scan_rsp_reg #(.BYTE_W(BYTE_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .rd_acc(rd_acc), .kind(kind), .in_win(in_win),
    .rd_byte(rd_byte), .synth_index(synth_index), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data)
  );
endmodule

// File: rtl/sus_scan_port_chk.sv
module sus_scan_port_chk #(
  parameter int                ADDR_W    = 8,
  parameter int                BYTE_W    = 8,
  parameter logic [ADDR_W-1:0] DATA_OFS  = 8'hF1,
  parameter logic [ADDR_W-1:0] INDEX_OFS = 8'hF2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scan_en,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [BYTE_W-1:0] rsp_data,
  input logic              load_valid
);
  // R12
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
  // R12
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && !req_write) |=> !rsp_valid);
  // R2
  snapshot_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_en) |-> !req_ready);
  // R7
  load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> !load_valid);
  // R7
  load_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> $past(req_valid && req_ready && req_write && scan_en && req_addr == DATA_OFS));
  // R9
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(!scan_en && req_addr == DATA_OFS)) |-> rsp_data == '0);
  // R11
  other_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_addr != DATA_OFS && req_addr != INDEX_OFS)) |-> rsp_data == '0);
endmodule

bind sus_scan_port sus_scan_port_chk #(
  .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .DATA_OFS(DATA_OFS), .INDEX_OFS(INDEX_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .req_valid(req_valid),
  .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .load_valid(load_valid)
);

// File: tb/test_sus_scan_port.sv
module test_sus_scan_port;
  localparam int CLK_P = 10;
  localparam int SB    = 268;
  localparam int NB    = 34;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scan_en = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [7:0]    req_addr = 8'h00;
  logic [7:0]    req_wdata = 8'h00;
  logic          rsp_valid;
  logic [7:0]    rsp_data;
  logic [7:0]    synth_index = 8'h00;
  logic [SB-1:0] cap_state = '0;
  logic          load_valid;
  logic [SB-1:0] load_state;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  sus_scan_port i_sus_scan_port (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .synth_index(synth_index), .cap_state(cap_state), .load_valid(load_valid),
    .load_state(load_state)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [271:0] act,
                     input logic [271:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_bytes [NB];
  int         m_ptr  = 0;
  bit         m_prev = 0;
  bit         m_cap;
  bit         e_rv = 0, e_lv = 0;
  logic [7:0] e_rd = 8'h00;
  string      e_tag = "R12";
  string      e_img_tag = "R1";

  function automatic logic [SB-1:0] model_img();
    logic [SB-1:0] v;
    for (int i = 0; i < SB; i++) v[i] = m_bytes[i/8][i%8];
    return v;
  endfunction

  initial for (int b = 0; b < NB; b++) m_bytes[b] = 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_prev = 0; e_rv = 0; e_lv = 0; e_rd = 8'h00;
      for (int b = 0; b < NB; b++) m_bytes[b] = 8'h00;
    end else begin
      m_cap = scan_en && !m_prev;
      chk(req_ready === !m_cap, "R2 ready", 272'(req_ready), 272'(!m_cap));
      e_rv = 0; e_lv = 0;
      if (m_cap) begin
        for (int b = 0; b < NB; b++)
          for (int j = 0; j < 8; j++)
            m_bytes[b][j] = (b*8+j < SB) ? cap_state[b*8+j] : 1'b0;
        m_ptr = 0; e_img_tag = "R2 capture";
      end else if (req_valid) begin
        if (!req_write) begin
          e_rv = 1;
          if (req_addr == 8'hF1) begin
            if (!scan_en)          begin e_rd = 8'h00; e_tag = "R9"; end
            else if (m_ptr >= NB)  begin e_rd = 8'h00; e_tag = "R8"; end
            else begin
              e_rd  = m_bytes[m_ptr];
              e_tag = (m_ptr == NB-1) ? "R4" : "R3 R5";
              m_ptr++;
            end
          end else if (req_addr == 8'hF2) begin
            e_rd = synth_index; e_tag = "R10";
          end else begin
            e_rd = 8'h00; e_tag = "R11";
          end
        end else if (req_addr == 8'hF1) begin
          if (!scan_en)         e_img_tag = "R9";
          else if (m_ptr >= NB) e_img_tag = "R8";
          else begin
            m_bytes[m_ptr] = (m_ptr == NB-1) ? (req_wdata & 8'h0F) : req_wdata;
            if (m_ptr == NB-1) e_lv = 1;
            e_img_tag = "R6 R5";
            m_ptr++;
          end
        end else begin
          e_img_tag = "R10 R11";
        end
      end
      m_prev = scan_en;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rsp_valid === e_rv, "R12", 272'(rsp_valid), 272'(e_rv));
      if (e_rv) chk(rsp_data === e_rd, e_tag, 272'(rsp_data), 272'(e_rd));
      chk(load_valid === e_lv, "R7", 272'(load_valid), 272'(e_lv));
      chk(load_state === model_img(), e_img_tag, 272'(load_state), 272'(model_img()));
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [SB-1:0] pat(input int s);
    logic [SB-1:0] v;
    for (int i = 0; i < SB; i++) v[i] = (((i * s) + (i / 3) + s) % 3) == 0;
    return v;
  endfunction

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; returns at the negedge after acceptance
  task automatic access(input bit wr, input logic [7:0] addr, input logic [7:0] d);
    bit acc;
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = d;
    do begin
      #(CLK_P/2 - 1);
      acc = req_ready;
      @(negedge clk);
    end while (!acc);
    req_valid = 1'b0;
  endtask

  task automatic set_scan(input bit v);
    scan_en = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(rsp_valid === 1'b0, "R1", 272'(rsp_valid), 272'(0));
    chk(rsp_data === 8'h00, "R1", 272'(rsp_data), 272'(0));
    chk(load_valid === 1'b0, "R1", 272'(load_valid), 272'(0));
    chk(load_state === '0, "R1", 272'(load_state), 272'(0));
    chk(req_ready === 1'b1, "R1", 272'(req_ready), 272'(1));

    // R10: index register, writes ignored
    synth_index = 8'h5A; access(0, 8'hF2, 8'h00);
    access(1, 8'hF2, 8'h33);
    synth_index = 8'hC3; access(0, 8'hF2, 8'h00);

    // R9 / R11: scan off, other addresses
    access(0, 8'hF1, 8'h00);
    access(1, 8'hF1, 8'hAB);
    access(0, 8'h10, 8'h00);
    access(1, 8'h10, 8'h77);
    access(0, 8'hF0, 8'h00);

    // R2, R3, R4, R8: save with request waiting across the snapshot
    cap_state = pat(1);
    scan_en = 1'b1;
    access(0, 8'hF1, 8'h00);
    for (int k = 1; k < NB + 2; k++) access(0, 8'hF1, 8'h00);
    set_scan(0);

    // R6, R7, R8: restore, last byte FFh, then writes past the end
    cap_state = pat(2);
    set_scan(1);
    idle(1);
    for (int k = 0; k < NB - 1; k++) access(1, 8'hF1, 8'((k * 37 + 11) & 8'hFF));
    access(1, 8'hF1, 8'hFF);
    idle(2);
    access(1, 8'hF1, 8'h5C);
    access(1, 8'hF1, 8'hA3);
    access(0, 8'hF1, 8'h00);
    set_scan(0);

    // R9: write with scan off leaves image alone
    access(1, 8'hF1, 8'h99);
    idle(1);

    // R5, R10: mixed reads and writes share the pointer; index does not move it
    cap_state = pat(5);
    set_scan(1);
    for (int k = 0; k < NB; k++) begin
      if (k % 3 == 1) begin
        synth_index = 8'(k);
        access(0, 8'hF2, 8'h00);
      end
      if (k % 2 == 0) access(0, 8'hF1, 8'h00);
      else            access(1, 8'hF1, 8'(8'hE0 ^ k));
      if (k % 5 == 0) idle(1);
    end
    idle(2);

    // R2: drop and re-raise scan mid-session rewinds and recaptures
    set_scan(0);
    cap_state = pat(7);
    set_scan(1);
    for (int k = 0; k < 10; k++) access(0, 8'hF1, 8'h00);
    set_scan(0);
    cap_state = pat(11);
    scan_en = 1'b1;
    access(0, 8'hF1, 8'h00);
    access(0, 8'hF1, 8'h00);
    access(1, 8'hF1, 8'h3C);
    access(0, 8'hF1, 8'h00);
    set_scan(0);
    idle(3);
    finish_run();
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_err++;
      $display("FAIL R12 watchdog: actual still running expected finished");
      finish_run();
    end
  end
endmodule